// File: doc/BRIEF.md
# Flash Power-State Recovery Sequencer

This block runs once after every reset, before the rest of the chip may erase or program the serial flash. It drives a simple request/acknowledge port into an existing SPI command engine. First it reads the 24-bit device identifier and compares it against a strict list of supported models from one flash vendor. Devices that match pass at once. Devices that do not match are probed through one byte of the serial flash parameter table. When that byte names the vendor, the block runs a power-state cycle. The cycle is deep power-down, then ultra-deep power-down, then exit, then a long wait, then release, then a short wait. After the cycle it reads the identifier again and checks it a second time.

A configuration input can turn the recovery support off. With support off, the block rejects any device that carries the vendor code and accepts every other device. The outcome is reported on a sticky done flag and a pass flag. A write-permit output rises only when the flow ends with a pass. The identifier read most recently is held on an output.

The two waits are counted in clock cycles. The cycle counts come from a clock-frequency parameter and two wait lengths in microseconds, so a bench can shorten the waits by lowering the frequency parameter.

Top module: `flash_wake_seq`

## Requirements
- R1: While reset is held and on leaving it, `done` and `wr_permit` are 0. The first command requested is an identifier read: opcode 0x9F, `cmd_addr_en`=0, `cmd_dummy`=0, `cmd_rx_bytes`=3. The engine returns the identifier on `cmd_rdata` with the vendor code in bits 23:16, the memory type in bits 15:8 and the capacity code in bits 7:0.
- R2: With `support_en`=1, an identifier is a strict match when its vendor code is 0x20 and one of these holds: type 0x41 with capacity 0x17..0x20, type 0x50 with capacity 0x15..0x16, or type 0x40 with capacity 0x13..0x20 (all bounds inclusive). A strict match ends the flow with `start_ok`=1 after exactly one command.
- R3: With `support_en`=1 and no strict match, the second command is a parameter-table read: opcode 0x5A, `cmd_addr_en`=1, `cmd_addr`=0x000010, `cmd_dummy`=8, `cmd_rx_bytes`=1. Only `cmd_rdata[7:0]` is used. If that byte is not 0x20, the flow ends with `start_ok`=1 after two commands.
- R4: If the parameter byte equals 0x20, the block issues 0xB9, 0x79, 0xFF, 0xAB and then 0x9F, in that order. Each of the four power-state opcodes has no address, no dummy clocks and 0 receive bytes.
- R5: Between the completion of 0xFF and the request of 0xAB, `cmd_req` stays low for exactly (CLK_HZ/1e6)*LONG_US cycles. Between the completion of 0xAB and the request of the second 0x9F, it stays low for exactly (CLK_HZ/1e6)*SHORT_US cycles.
- R6: The second identifier is stored on `dev_id`. The flow ends with `start_ok`=1 if that identifier is a strict match and with `start_ok`=0 if it is not. Without recovery, `dev_id` keeps the first identifier.
- R7: With `support_en`=0, only the first identifier is read and only its vendor code is looked at. A vendor code of 0x20 gives `start_ok`=0. Any other code gives `start_ok`=1. In both cases exactly one command is issued.
- R8: Once `done` rises it stays 1, `start_ok` stays constant, and no further command is requested until the next reset.
- R9: `wr_permit` is 1 exactly when `done`=1 and `start_ok`=1. It is 0 before completion and 0 after a failing completion.
- R10: A request holds `cmd_req` and all command fields steady until the cycle in which `cmd_ack` is 1. The next command, if there is one, may be presented in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| support_en | input | 1 | 1 enables the recovery flow; 0 rejects vendor devices |
| cmd_req | output | 1 | Command request to the SPI engine |
| cmd_op | output | 8 | Opcode of the requested command |
| cmd_addr_en | output | 1 | Command carries a 24-bit address phase |
| cmd_addr | output | 24 | Address for the address phase |
| cmd_dummy | output | 4 | Dummy clocks before the receive phase |
| cmd_rx_bytes | output | 2 | Bytes to receive (0 to 3) |
| cmd_ack | input | 1 | One-cycle completion strobe from the engine |
| cmd_rdata | input | 24 | Received bytes, right aligned, valid with cmd_ack |
| done | output | 1 | Flow finished (sticky) |
| start_ok | output | 1 | Flow result, meaningful when done is 1 |
| wr_permit | output | 1 | Erase/program may proceed |
| dev_id | output | 24 | Most recently read identifier |

## Verification
The first identifier is varied across the edges of each strict range: the lowest and highest capacity of each type, the values one step outside each range, foreign vendor codes and unlisted types. These cases separate a fast pass from a parameter-table probe. Parameter bytes equal to and different from the vendor code separate an early pass from the recovery cycle. The upper bits of the parameter response are filled with junk so that a wrong byte lane is exposed. In the recovery runs the second identifier is either strict or not, which tells a good re-check from a failed one and also shows that the stored identifier is replaced. With support turned off, a strict identifier, a non-strict vendor identifier and a foreign identifier show that the verdict depends on the vendor code alone.

// File: rtl/fwseq_pkg.sv
package fwseq_pkg;

  localparam logic [7:0]  VENDOR_CODE = 8'h20;

  localparam logic [7:0]  OP_RDID  = 8'h9F;
  localparam logic [7:0]  OP_PTAB  = 8'h5A;
  localparam logic [7:0]  OP_DPD   = 8'hB9;
  localparam logic [7:0]  OP_UDPD  = 8'h79;
  localparam logic [7:0]  OP_XUDPD = 8'hFF;
  localparam logic [7:0]  OP_REL   = 8'hAB;

  localparam logic [23:0] PTAB_ADDR  = 24'h000010;
  localparam logic [3:0]  PTAB_DUMMY = 4'd8;

  typedef enum logic [3:0] {
    ST_RDID,
    ST_EVAL1,
    ST_PTAB,
    ST_DPD,
    ST_UDPD,
    ST_XUDPD,
    ST_WLONG,
    ST_REL,
    ST_WSHORT,
    ST_REID,
    ST_EVAL2,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic [7:0] mtype;
    logic [7:0] lo;
    logic [7:0] hi;
  } model_rng_t;

  localparam int NUM_RNG = 3;
  localparam model_rng_t MODEL_RNG [NUM_RNG] = '{
    '{mtype: 8'h50, lo: 8'h15, hi: 8'h16},
    '{mtype: 8'h41, lo: 8'h17, hi: 8'h20},
    '{mtype: 8'h40, lo: 8'h13, hi: 8'h20}
  };

endpackage

// File: rtl/fwseq_id_match.sv
module fwseq_id_match
  import fwseq_pkg::*;
#(
  parameter int NRNG = NUM_RNG
) (
  input  logic [23:0] id,
  output logic        vendor_hit,
  output logic        strict_hit
);

  logic [NRNG-1:0] rng_hit;

  for (genvar g = 0; g < NRNG; g++) begin : g_rng
    assign rng_hit[g] = (id[15:8] == MODEL_RNG[g].mtype) &&
                        (id[7:0]  >= MODEL_RNG[g].lo)    &&
                        (id[7:0]  <= MODEL_RNG[g].hi);
  end

  always_comb begin
    vendor_hit = (id[23:16] == VENDOR_CODE);
    strict_hit = vendor_hit && (|rng_hit);
  end

endmodule

// File: rtl/fwseq_wait_timer.sv
module fwseq_wait_timer #(
  parameter int LONG_CYC  = 160000,
  parameter int SHORT_CYC = 1600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sel_long,
  output logic expire
);

  localparam int MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          at_last;

  always_comb begin
    at_last = sel_long ? (cnt_q == LONG_LAST) : (cnt_q == SHORT_LAST);
    expire  = run && at_last;
    cnt_d   = run ? (cnt_q + 1'b1) : '0;
    cnt_en  = run || (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R5
  timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !expire) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R5
  timer_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/fwseq_ctrl.sv
module fwseq_ctrl
  import fwseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        support_en,
  input  logic        cmd_ack,
  input  logic [23:0] cmd_rdata,
  input  logic        vendor_hit,
  input  logic        strict_hit,
  input  logic        wait_expire,
  output logic        cmd_req,
  output logic [7:0]  cmd_op,
  output logic        cmd_addr_en,
  output logic [23:0] cmd_addr,
  output logic [3:0]  cmd_dummy,
  output logic [1:0]  cmd_rx_bytes,
  output logic        wait_run,
  output logic        wait_long,
  output logic        done,
  output logic        pass,
  output logic [23:0] id_q
);

  seq_state_e  state_q, state_d;
  logic [23:0] id_d;
  logic        id_en;
  logic        pass_q, pass_d, pass_en;

  // next-state logic
  always_comb begin
    state_d = state_q;
    id_d    = cmd_rdata;
    id_en   = 1'b0;
    pass_d  = pass_q;
    pass_en = 1'b0;
    unique case (state_q)
      ST_RDID: begin
        if (cmd_ack) begin
          state_d = ST_EVAL1;
          id_en   = 1'b1;
        end
      end
      ST_EVAL1: begin
        if (!support_en) begin
          state_d = ST_DONE;
          pass_d  = !vendor_hit;
          pass_en = 1'b1;
        end else if (strict_hit) begin
          state_d = ST_DONE;
          pass_d  = 1'b1;
          pass_en = 1'b1;
        end else begin
          state_d = ST_PTAB;
        end
      end
      ST_PTAB: begin
        if (cmd_ack) begin
          if (cmd_rdata[7:0] == VENDOR_CODE) begin
            state_d = ST_DPD;
          end else begin
            state_d = ST_DONE;
            pass_d  = 1'b1;
            pass_en = 1'b1;
          end
        end
      end
      ST_DPD:    if (cmd_ack) state_d = ST_UDPD;
      ST_UDPD:   if (cmd_ack) state_d = ST_XUDPD;
      ST_XUDPD:  if (cmd_ack) state_d = ST_WLONG;
      ST_WLONG:  if (wait_expire) state_d = ST_REL;
      ST_REL:    if (cmd_ack) state_d = ST_WSHORT;
      ST_WSHORT: if (wait_expire) state_d = ST_REID;
      ST_REID: begin
        if (cmd_ack) begin
          state_d = ST_EVAL2;
          id_en   = 1'b1;
        end
      end
      ST_EVAL2: begin
        state_d = ST_DONE;
        pass_d  = strict_hit;
        pass_en = 1'b1;
      end
      ST_DONE: state_d = ST_DONE;
      default: begin
        state_d = ST_DONE;
        pass_d  = 1'b0;
        pass_en = 1'b1;
      end
    endcase
  end

  // command field decode
  always_comb begin
    cmd_req      = 1'b0;
    cmd_op       = 8'h00;
    cmd_addr_en  = 1'b0;
    cmd_addr     = '0;
    cmd_dummy    = '0;
    cmd_rx_bytes = 2'd0;
    unique case (state_q)
      ST_RDID, ST_REID: begin
        cmd_req      = 1'b1;
        cmd_op       = OP_RDID;
        cmd_rx_bytes = 2'd3;
      end
      ST_PTAB: begin
        cmd_req      = 1'b1;
        cmd_op       = OP_PTAB;
        cmd_addr_en  = 1'b1;
        cmd_addr     = PTAB_ADDR;
        cmd_dummy    = PTAB_DUMMY;
        cmd_rx_bytes = 2'd1;
      end
      ST_DPD:   begin cmd_req = 1'b1; cmd_op = OP_DPD;   end
      ST_UDPD:  begin cmd_req = 1'b1; cmd_op = OP_UDPD;  end
      ST_XUDPD: begin cmd_req = 1'b1; cmd_op = OP_XUDPD; end
      ST_REL:   begin cmd_req = 1'b1; cmd_op = OP_REL;   end
      default: ;
    endcase
  end

  always_comb begin
    wait_run  = (state_q == ST_WLONG) || (state_q == ST_WSHORT);
    wait_long = (state_q == ST_WLONG);
    done      = (state_q == ST_DONE);
    pass      = pass_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RDID;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= '0;
    end else if (id_en) begin
      id_q <= id_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= 1'b0;
    end else if (pass_en) begin
      pass_q <= pass_d;
    end
  end

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R8
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_req);

  // R6
  verdict_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(pass));

  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_op) && $stable(cmd_addr_en)
                                && $stable(cmd_rx_bytes)));

  // R4
  udpd_then_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_ack && cmd_op == OP_UDPD) |=> (cmd_req && cmd_op == OP_XUDPD));

endmodule

// File: rtl/flash_wake_seq.sv
module flash_wake_seq
  import fwseq_pkg::*;
#(
  parameter int CLK_HZ   = 80_000_000,
  parameter int LONG_US  = 2000,
  parameter int SHORT_US = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        support_en,
  output logic        cmd_req,
  output logic [7:0]  cmd_op,
  output logic        cmd_addr_en,
  output logic [23:0] cmd_addr,
  output logic [3:0]  cmd_dummy,
  output logic [1:0]  cmd_rx_bytes,
  input  logic        cmd_ack,
  input  logic [23:0] cmd_rdata,
  output logic        done,
  output logic        start_ok,
  output logic        wr_permit,
  output logic [23:0] dev_id
);

  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int LONG_RAW   = CYC_PER_US * LONG_US;
  localparam int SHORT_RAW  = CYC_PER_US * SHORT_US;
  localparam int LONG_CYC   = (LONG_RAW  < 1) ? 1 : LONG_RAW;
  localparam int SHORT_CYC  = (SHORT_RAW < 1) ? 1 : SHORT_RAW;

  logic vendor_hit, strict_hit;
  logic wait_run, wait_long, wait_expire;
  logic pass;

  fwseq_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .support_en   (support_en),
    .cmd_ack      (cmd_ack),
    .cmd_rdata    (cmd_rdata),
    .vendor_hit   (vendor_hit),
    .strict_hit   (strict_hit),
    .wait_expire  (wait_expire),
    .cmd_req      (cmd_req),
    .cmd_op       (cmd_op),
    .cmd_addr_en  (cmd_addr_en),
    .cmd_addr     (cmd_addr),
    .cmd_dummy    (cmd_dummy),
    .cmd_rx_bytes (cmd_rx_bytes),
    .wait_run     (wait_run),
    .wait_long    (wait_long),
    .done         (done),
    .pass         (pass),
    .id_q         (dev_id)
  );

  fwseq_id_match u_match (
    .id         (dev_id),
    .vendor_hit (vendor_hit),
    .strict_hit (strict_hit)
  );

  fwseq_wait_timer #(
    .LONG_CYC  (LONG_CYC),
    .SHORT_CYC (SHORT_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (wait_run),
    .sel_long (wait_long),
    .expire   (wait_expire)
  );

  always_comb begin
    start_ok  = pass;
    wr_permit = done && pass;
  end

  // R9
  permit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_permit |=> wr_permit);

  // R9
  permit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_permit |-> !cmd_req);

  // R5
  no_cmd_while_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_run |-> !cmd_req);

endmodule

// File: tb/flash_wake_seq_tb_top.sv
`timescale 1ns/1ps
module flash_wake_seq_tb_top;

  localparam int CLK_HZ    = 4_000_000;
  localparam int LONG_US   = 2000;
  localparam int SHORT_US  = 20;
  localparam int LONG_EXP  = (CLK_HZ / 1_000_000) * LONG_US;
  localparam int SHORT_EXP = (CLK_HZ / 1_000_000) * SHORT_US;
  localparam int NVEC      = 15;
  localparam int WDOG      = 190000;

  // {support(1), first id(24), table byte(8), second id(24), exp ok(1), exp cmds(4)}
  localparam logic [61:0] VEC [NVEC] = '{
    {1'b1, 24'h204017, 8'h00, 24'h000000, 1'b1, 4'd1},
    {1'b1, 24'h204013, 8'h00, 24'h000000, 1'b1, 4'd1},
    {1'b1, 24'h204020, 8'h00, 24'h000000, 1'b1, 4'd1},
    {1'b1, 24'h205015, 8'h00, 24'h000000, 1'b1, 4'd1},
    {1'b1, 24'h205016, 8'h00, 24'h000000, 1'b1, 4'd1},
    {1'b1, 24'h204012, 8'h00, 24'h000000, 1'b1, 4'd2},
    {1'b1, 24'hC84017, 8'hC8, 24'h000000, 1'b1, 4'd2},
    {1'b1, 24'h204121, 8'h1F, 24'h000000, 1'b1, 4'd2},
    {1'b1, 24'h204116, 8'h20, 24'h204117, 1'b1, 4'd7},
    {1'b1, 24'h205017, 8'h20, 24'h205017, 1'b0, 4'd7},
    {1'b1, 24'h004121, 8'h20, 24'h000000, 1'b0, 4'd7},
    {1'b1, 24'h204221, 8'h20, 24'h204120, 1'b1, 4'd7},
    {1'b0, 24'h204017, 8'h00, 24'h000000, 1'b0, 4'd1},
    {1'b0, 24'hEF4017, 8'h00, 24'h000000, 1'b1, 4'd1},
    {1'b0, 24'h204012, 8'h00, 24'h000000, 1'b0, 4'd1}
  };

  logic        clk;
  logic        rst_n;
  logic        support_en;
  logic        cmd_req;
  logic [7:0]  cmd_op;
  logic        cmd_addr_en;
  logic [23:0] cmd_addr;
  logic [3:0]  cmd_dummy;
  logic [1:0]  cmd_rx_bytes;
  logic        cmd_ack;
  logic [23:0] cmd_rdata;
  logic        done;
  logic        start_ok;
  logic        wr_permit;
  logic [23:0] dev_id;

  flash_wake_seq #(
    .CLK_HZ   (CLK_HZ),
    .LONG_US  (LONG_US),
    .SHORT_US (SHORT_US)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .support_en   (support_en),
    .cmd_req      (cmd_req),
    .cmd_op       (cmd_op),
    .cmd_addr_en  (cmd_addr_en),
    .cmd_addr     (cmd_addr),
    .cmd_dummy    (cmd_dummy),
    .cmd_rx_bytes (cmd_rx_bytes),
    .cmd_ack      (cmd_ack),
    .cmd_rdata    (cmd_rdata),
    .done         (done),
    .start_ok     (start_ok),
    .wr_permit    (wr_permit),
    .dev_id       (dev_id)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int total;
  int fails;
  int cyc;

  // engine model state
  logic [23:0] resp_a, resp_b;
  logic [7:0]  resp_pt;
  logic [2:0]  lat;
  int          ncmd;
  int          nrd;
  logic [7:0]  log_op [16];
  logic        attr_bad;
  int          idle [16];
  logic        hold_bad, permit_bad, quiet_bad;
  logic        pv_req, pv_ack;
  logic [7:0]  pv_op;

  function automatic logic attr_good(input logic [7:0] op, input logic ae,
                                     input logic [23:0] ad, input logic [3:0] dm,
                                     input logic [1:0] rx);
    if (op == 8'h9F) return !ae && dm == 4'd0 && rx == 2'd3;
    if (op == 8'h5A) return ae && ad == 24'h000010 && dm == 4'd8 && rx == 2'd1;
    return !ae && dm == 4'd0 && rx == 2'd0;
  endfunction

  // SPI engine model: fixed latency, registered ack and data
  initial begin
    cmd_ack   = 1'b0;
    cmd_rdata = '0;
    lat       = '0;
    ncmd      = 0;
    nrd       = 0;
    attr_bad  = 1'b0;
    forever begin
      @(posedge clk);
      if (!rst_n) begin
        cmd_ack  <= 1'b0;
        lat      <= '0;
        ncmd     <= 0;
        nrd      <= 0;
        attr_bad <= 1'b0;
      end else begin
        cmd_ack <= 1'b0;
        if (cmd_req && !cmd_ack) begin
          if (lat == 3'd3) begin
            cmd_ack <= 1'b1;
            lat     <= '0;
            if (ncmd < 16) log_op[ncmd] <= cmd_op;
            ncmd    <= ncmd + 1;
            if (!attr_good(cmd_op, cmd_addr_en, cmd_addr, cmd_dummy, cmd_rx_bytes))
              attr_bad <= 1'b1;
            if (cmd_op == 8'h9F) begin
              cmd_rdata <= (nrd == 0) ? resp_a : resp_b;
              nrd       <= nrd + 1;
            end else if (cmd_op == 8'h5A) begin
              cmd_rdata <= {16'hFFFF, resp_pt};
            end else begin
              cmd_rdata <= 24'hFFFFFF;
            end
          end else begin
            lat <= lat + 3'd1;
          end
        end
      end
    end
  end

  // monitors, sampled away from the active edge
  initial begin
    pv_req = 1'b0;
    pv_ack = 1'b0;
    pv_op  = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!cmd_req && !done && ncmd < 16) idle[ncmd] = idle[ncmd] + 1;
        if (pv_req && !pv_ack && (!cmd_req || cmd_op != pv_op)) hold_bad = 1'b1;
        if (wr_permit && !done) permit_bad = 1'b1;
        if (done && cmd_req) quiet_bad = 1'b1;
      end
      pv_req = cmd_req;
      pv_ack = cmd_ack;
      pv_op  = cmd_op;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic start_run(input logic sup, input logic [23:0] ia,
                           input logic [7:0] pt, input logic [23:0] ib);
    support_en = sup;
    resp_a     = ia;
    resp_pt    = pt;
    resp_b     = ib;
    rst_n      = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 16; i++) idle[i] = 0;
    hold_bad   = 1'b0;
    permit_bad = 1'b0;
    quiet_bad  = 1'b0;
    rst_n      = 1'b1;
    for (int t = 0; t < 20000 && !done; t++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // watchdog
  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WDOG) begin
        total++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
      end
    end
  end

  initial begin
    total      = 0;
    fails      = 0;
    rst_n      = 1'b0;
    support_en = 1'b1;
    resp_a     = 24'h204017;
    resp_b     = '0;
    resp_pt    = '0;
    hold_bad   = 1'b0;
    permit_bad = 1'b0;
    quiet_bad  = 1'b0;
    for (int i = 0; i < 16; i++) idle[i] = 0;

    // R1: reset state and first command
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", 32'(done), 32'd0);
    chk("R1", "permit in reset", 32'(wr_permit), 32'd0);
    chk("R1", "first request", 32'(cmd_req), 32'd1);
    chk("R1", "first opcode", 32'(cmd_op), 32'h9F);
    chk("R1", "first rx bytes / addr", 32'({cmd_addr_en, cmd_dummy, cmd_rx_bytes}), 32'd3);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      logic        sup, eok;
      logic [23:0] ia, ib, eid;
      logic [7:0]  pt;
      logic [3:0]  en;
      string       tag;
      sup = VEC[v][61];
      ia  = VEC[v][60:37];
      pt  = VEC[v][36:29];
      ib  = VEC[v][28:5];
      eok = VEC[v][4];
      en  = VEC[v][3:0];
      eid = (en == 4'd7) ? ib : ia;
      if (!sup)            tag = "R7";
      else if (en == 4'd7) tag = "R6";
      else if (en == 4'd2) tag = "R3";
      else                 tag = "R2";
      start_run(sup, ia, pt, ib);
      chk("R8", $sformatf("vec %0d done", v), 32'(done), 32'd1);
      chk(tag, $sformatf("vec %0d result", v), 32'(start_ok), 32'(eok));
      chk("R9", $sformatf("vec %0d permit", v), 32'(wr_permit), 32'(eok));
      chk(tag, $sformatf("vec %0d command count", v), 32'(ncmd), 32'(en));
      chk("R6", $sformatf("vec %0d dev_id", v), 32'(dev_id), 32'(eid));
      chk("R4", $sformatf("vec %0d command fields", v), 32'(attr_bad), 32'd0);
      chk("R10", $sformatf("vec %0d request hold", v), 32'(hold_bad), 32'd0);
      chk("R9", $sformatf("vec %0d early permit", v), 32'(permit_bad), 32'd0);
      chk("R8", $sformatf("vec %0d request after done", v), 32'(quiet_bad), 32'd0);
      if (en == 4'd7) begin
        chk("R4", $sformatf("vec %0d opcode order", v),
            {log_op[2], log_op[3], log_op[4], log_op[5]}, 32'hB979FFAB);
        chk("R4", $sformatf("vec %0d reread opcode", v), 32'(log_op[6]), 32'h9F);
        chk("R3", $sformatf("vec %0d table opcode", v), 32'(log_op[1]), 32'h5A);
        chk("R5", $sformatf("vec %0d long wait", v), 32'(idle[5]), 32'(LONG_EXP));
        chk("R5", $sformatf("vec %0d short wait", v), 32'(idle[6]), 32'(SHORT_EXP));
      end
    end

    // R8: completion persists and the bus stays quiet
    start_run(1'b1, 24'h204012, 8'h05, 24'h0);
    repeat (60) @(negedge clk);
    chk("R8", "done sticky", 32'(done), 32'd1);
    chk("R8", "result sticky", 32'(start_ok), 32'd1);
    chk("R8", "no extra commands", 32'(ncmd), 32'd2);
    chk("R8", "quiet after done", 32'(quiet_bad), 32'd0);

    // R9: a failing flow never raises permit, even after waiting
    start_run(1'b0, 24'h205015, 8'h00, 24'h0);
    repeat (40) @(negedge clk);
    chk("R9", "permit after fail", 32'(wr_permit), 32'd0);
    chk("R7", "disabled vendor fail", 32'(start_ok), 32'd0);

    // R1: reset mid-flow returns to the initial state
    support_en = 1'b1;
    resp_a     = 24'h204116;
    resp_pt    = 8'h20;
    resp_b     = 24'h204117;
    rst_n      = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "done after mid-flow reset", 32'(done), 32'd0);
    chk("R1", "opcode after mid-flow reset", 32'(cmd_op), 32'h9F);
    chk("R1", "permit after mid-flow reset", 32'(wr_permit), 32'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule